// File: doc/BRIEF.md
# Two-Output Level/Edge Interrupt Aggregator

This block gathers a wide vector of interrupt request lines, organised as a number of 32-bit groups (seven by default, 224 lines in all), and folds them into two active-high parent interrupt lines. Each line has four attributes held in software-programmable bit arrays: detection mode (edge or level), sense (inverted or not), destination (parent 0 or parent 1) and an enable. Line n lives in bit n mod 32 of word n/32 of every array.

Edge-mode lines pass a two-flop synchroniser, then set a sticky pending bit on the selected transition. Software removes that bit by writing a one to it. Level-mode lines are pending for as long as the conditioned input is active. For each parent, software reads words of masked pending state, and a single summary word names the groups that hold work, so a handler can go straight to the right word.

Access uses a simple request bus with one-cycle read latency and a region select. Region 0 holds the four attribute arrays. Region 1 holds the clear array, the two masked views and the summary word.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset both parent outputs are low, every mode bit reads 1 (edge), every sense bit reads 0, every destination bit reads 1 (parent 0), every enable reads 0, and all masked views and the summary read 0.
- R2: A read request (req_valid=1, req_write=0) produces rsp_valid=1 with the data in the following cycle, and rsp_valid is 0 in any cycle after a cycle with no read request.
- R3: Region 0 word arrays sit at byte offsets 0x00 (mode), 0x1C (sense), 0x38 (destination) and 0x54 (enable), one 32-bit word per group, and a written word reads back unchanged.
- R4: A level-mode line (mode bit 0) is pending while its synchronised input XOR its sense bit is 1: sense 0 means active-high, sense 1 means active-low.
- R5: An edge-mode line (mode bit 1) sets a sticky pending bit on a rising input edge when its sense bit is 0, and on a falling edge when its sense bit is 1. The bit stays set after the input returns, and changing the sense bit alone creates no edge.
- R6: Writing region 1 offset 0x00 plus 4×group clears the edge-pending bits written as 1. Bits written as 0 are unaffected.
- R7: When a detected edge and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R8: A masked view bit is 1 only when the line is pending, enabled, and routed to that parent. The parent 1 view is at region 1 offset 0x1C and the parent 0 view is at 0x38, one word per group. Disabling a line hides it from the view, and re-enabling it shows any edge state that was retained.
- R9: The summary word at region 1 offset 0x7C has bit g (for g below the group count) set when group g has a masked bit for parent 1, and bit 8+g set when group g has a masked bit for parent 0.
- R10: Each parent output is an active-high registered level equal to the OR of its summary bits from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NG*DW | Interrupt request lines, asynchronous |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 1 | 0 = attribute region, 1 = status/clear region |
| req_addr | input | AW | Byte offset within the region |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| irq0_o | output | 1 | Parent interrupt 0, active high |
| irq1_o | output | 1 | Parent interrupt 1, active high |

## Verification
The bench drives one level-mode line and one edge-mode line in different groups, each routed to a different parent. For each line it tries high and low sense. A level line that drops out once the input is released tells the level path from the sticky edge path. A rising input that leaves a falling-sense line idle shows that edge polarity is honoured. Clear writes with the target bit at 0 and then at 1 separate write-one from write-any. An edge timed to arrive in the same cycle as its clear shows which of the two wins. Toggling the enable on a retained edge, and running both parents at once, show that masking, routing and the two summary halves stay independent.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Attribute arrays in region 0, in address order
  typedef enum logic [1:0] {
    ARR_MODE  = 2'd0,
    ARR_SENSE = 2'd1,
    ARR_DEST  = 2'd2,
    ARR_EN    = 2'd3
  } attr_arr_e;

  // Word arrays in region 1, in address order
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_VIEW1 = 2'd1,
    ST_VIEW0 = 2'd2
  } stat_arr_e;

  localparam int SUMMARY_WORD = 31;
  localparam int VIEW0_SHIFT  = 8;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int W = 224
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_o <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/irq_attr_regs.sv
module irq_attr_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NG = 7,
  parameter int DW = 32,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int NS = NG * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    sel_arr,
  input  logic [GW-1:0] sel_word,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NS-1:0] mode_v,
  output logic [NS-1:0] sense_v,
  output logic [NS-1:0] dest_v,
  output logic [NS-1:0] en_v
);
  logic [DW-1:0] mode_q  [NG];
  logic [DW-1:0] sense_q [NG];
  logic [DW-1:0] dest_q  [NG];
  logic [DW-1:0] en_q    [NG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        mode_q[g]  <= '1;
        sense_q[g] <= '0;
        dest_q[g]  <= '1;
        en_q[g]    <= '0;
      end
    end else if (wr_en) begin
      case (attr_arr_e'(sel_arr))
        ARR_MODE:  mode_q[sel_word]  <= wdata;
        ARR_SENSE: sense_q[sel_word] <= wdata;
        ARR_DEST:  dest_q[sel_word]  <= wdata;
        default:   en_q[sel_word]    <= wdata;
      endcase
    end
  end

  always_comb begin
    case (attr_arr_e'(sel_arr))
      ARR_MODE:  rdata = mode_q[sel_word];
      ARR_SENSE: rdata = sense_q[sel_word];
      ARR_DEST:  rdata = dest_q[sel_word];
      default:   rdata = en_q[sel_word];
    endcase
  end

  for (genvar g = 0; g < NG; g++) begin : g_flat
    assign mode_v[g*DW +: DW]  = mode_q[g];
    assign sense_v[g*DW +: DW] = sense_q[g];
    assign dest_v[g*DW +: DW]  = dest_q[g];
    assign en_v[g*DW +: DW]    = en_q[g];
  end
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
  parameter int NG = 7,
  parameter int DW = 32,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int NS = NG * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] sync_i,
  input  logic [NS-1:0] prev_i,
  input  logic [NS-1:0] mode_v,
  input  logic [NS-1:0] sense_v,
  input  logic          clr_we,
  input  logic [GW-1:0] clr_word,
  input  logic [DW-1:0] clr_data,
  output logic [NS-1:0] pend_v
);
  logic [NS-1:0] act_now, act_old, edge_hit, clr_mask, edge_q;

  assign act_now  = sync_i ^ sense_v;
  assign act_old  = prev_i ^ sense_v;
  assign edge_hit = act_now & ~act_old;

  for (genvar g = 0; g < NG; g++) begin : g_clr
    assign clr_mask[g*DW +: DW] = (clr_we && (clr_word == GW'(g))) ? clr_data : '0;
  end

  // Edge has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) edge_q <= '0;
    else     edge_q <= (edge_q & ~clr_mask) | edge_hit;
  end

  assign pend_v = (mode_v & edge_q) | (~mode_v & act_now);

  // Sticky: a set bit survives unless a clear hit it
  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ((($past(edge_q) & ~$past(clr_mask)) & ~edge_q) == '0));

  // A bit rises only from a detected edge
  p_set_by_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (((edge_q & ~$past(edge_q)) & ~$past(edge_hit)) == '0));

  // An edge coinciding with a clear keeps the bit
  p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(edge_hit) & ~edge_q) == '0));

  // A bit falls only where a one was written
  p_clear_only_ones_r6: assert property (@(posedge clk) disable iff (rst)
    ((($past(edge_q) & ~edge_q) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NG = 7,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NG*DW-1:0] src_i,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_region,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             irq0_o,
  output logic             irq1_o
);
  localparam int NS = NG * DW;
  localparam int IW = AW - 2;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;

  logic [IW-1:0] widx, arr_sel;
  logic [GW-1:0] word_sel;
  logic          attr_hit, attr_wr, clr_we, rd_req;
  logic [DW-1:0] attr_rdata, stat_rdata, rd_mux, summary;
  logic [NS-1:0] sync_v, prev_v, mode_v, sense_v, dest_v, en_v, pend_v;
  logic [NS-1:0] view0, view1;
  logic [NG-1:0] grp0, grp1;

  assign widx     = req_addr[AW-1:2];
  assign arr_sel  = widx / IW'(NG);
  assign word_sel = GW'(widx % IW'(NG));
  assign attr_hit = (arr_sel < IW'(4));
  assign attr_wr  = req_valid && req_write && !req_region && attr_hit;
  assign clr_we   = req_valid && req_write && req_region && (arr_sel == IW'(ST_CLEAR));
  assign rd_req   = req_valid && !req_write;

  irq_sync_bank #(.W(NS)) u_sync (
    .clk(clk), .rst(rst), .async_i(src_i), .sync_o(sync_v), .prev_o(prev_v)
  );

  irq_attr_regs #(.NG(NG), .DW(DW)) u_attr (
    .clk(clk), .rst(rst), .wr_en(attr_wr), .sel_arr(arr_sel[1:0]),
    .sel_word(word_sel), .wdata(req_wdata), .rdata(attr_rdata),
    .mode_v(mode_v), .sense_v(sense_v), .dest_v(dest_v), .en_v(en_v)
  );

  irq_pend_core #(.NG(NG), .DW(DW)) u_pend (
    .clk(clk), .rst(rst), .sync_i(sync_v), .prev_i(prev_v),
    .mode_v(mode_v), .sense_v(sense_v), .clr_we(clr_we),
    .clr_word(word_sel), .clr_data(req_wdata), .pend_v(pend_v)
  );

  assign view0 = pend_v & en_v & dest_v;
  assign view1 = pend_v & en_v & ~dest_v;

  for (genvar g = 0; g < NG; g++) begin : g_sum
    assign grp0[g] = |view0[g*DW +: DW];
    assign grp1[g] = |view1[g*DW +: DW];
  end

  always_comb begin
    summary = '0;
    summary[NG-1:0] = grp1;
    summary[VIEW0_SHIFT +: NG] = grp0;
  end

  always_comb begin
    if (widx == IW'(SUMMARY_WORD))           stat_rdata = summary;
    else if (arr_sel == IW'(ST_VIEW1))       stat_rdata = view1[word_sel*DW +: DW];
    else if (arr_sel == IW'(ST_VIEW0))       stat_rdata = view0[word_sel*DW +: DW];
    else                                     stat_rdata = '0;
  end

  always_comb begin
    if (req_region)    rd_mux = stat_rdata;
    else if (attr_hit) rd_mux = attr_rdata;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq0_o    <= 1'b0;
      irq1_o    <= 1'b0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_mux : '0;
      irq0_o    <= |grp0;
      irq1_o    <= |grp1;
    end
  end

  p_read_resp_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);
  p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);
  p_irq0_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq0_o |-> $past(|view0));
  p_irq1_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq1_o |-> $past(|view1));
  p_view_routed_r8: assert property (@(posedge clk) disable iff (rst)
    ((view0 & view1) == '0) && (((view0 | view1) & ~en_v) == '0));
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 7;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic CFG = 1'b0;
  localparam logic STS = 1'b1;

  logic             clk = 1'b0;
  logic             rst;
  logic [NG*DW-1:0] src;
  logic             req_valid, req_write, req_region;
  logic [AW-1:0]    req_addr;
  logic [DW-1:0]    req_wdata;
  logic             rsp_valid;
  logic [DW-1:0]    rsp_rdata;
  logic             irq0_o, irq1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_ctrl #(.NG(NG), .DW(DW), .AW(AW)) u_dual_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .req_valid(req_valid),
    .req_write(req_write), .req_region(req_region), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic reg_region, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_region = reg_region; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic reg_region, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_region = reg_region; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever the design answers a read
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=unexpected response %h expected=none", rsp_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; src = '0;
    req_valid = 1'b0; req_write = 1'b0; req_region = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 irq0 reset", {31'd0, irq0_o}, 0);
    chk("R1 irq1 reset", {31'd0, irq1_o}, 0);
    bus_read(CFG, 8'h00, 32'hFFFF_FFFF, "R1 mode w0");
    bus_read(CFG, 8'h18, 32'hFFFF_FFFF, "R1 mode w6");
    bus_read(CFG, 8'h28, 32'h0, "R1 sense w3");
    bus_read(CFG, 8'h38, 32'hFFFF_FFFF, "R1 dest w0");
    bus_read(CFG, 8'h54, 32'h0, "R1 enable w0");
    bus_read(STS, 8'h38, 32'h0, "R1 view0 w0");
    bus_read(STS, 8'h7C, 32'h0, "R1 summary");

    // R3 address map readback
    bus_write(CFG, 8'h24, 32'hA5A5_0000);
    bus_read(CFG, 8'h24, 32'hA5A5_0000, "R3 sense w2");
    bus_write(CFG, 8'h68, 32'h1234_5678);
    bus_read(CFG, 8'h68, 32'h1234_5678, "R3 enable w5");
    bus_write(CFG, 8'h24, 32'h0);
    bus_write(CFG, 8'h68, 32'h0);

    // R4 level line 40 (group 1 bit 8), parent 0
    bus_write(CFG, 8'h04, ~32'h100);
    bus_read(CFG, 8'h04, 32'hFFFF_FEFF, "R3 mode w1");
    bus_write(CFG, 8'h58, 32'h100);
    idle(5);
    bus_read(STS, 8'h3C, 32'h0, "R4 level idle");
    src[40] = 1'b1; idle(5);
    chk("R4 irq0 level high", {31'd0, irq0_o}, 1);
    chk("R8 irq1 unrouted", {31'd0, irq1_o}, 0);
    bus_read(STS, 8'h3C, 32'h100, "R4 view0 w1");
    bus_read(STS, 8'h20, 32'h0, "R8 view1 w1");
    bus_read(STS, 8'h7C, 32'h200, "R9 summary out0 group1");
    src[40] = 1'b0; idle(5);
    chk("R4 irq0 level released", {31'd0, irq0_o}, 0);
    bus_read(STS, 8'h3C, 32'h0, "R4 level released");
    bus_write(CFG, 8'h20, 32'h100); idle(5);
    chk("R4 active-low asserted", {31'd0, irq0_o}, 1);
    bus_read(STS, 8'h3C, 32'h100, "R4 active-low view");
    src[40] = 1'b1; idle(5);
    chk("R4 active-low released", {31'd0, irq0_o}, 0);
    src[40] = 1'b0;
    bus_write(CFG, 8'h20, 32'h0);
    bus_write(CFG, 8'h58, 32'h0);

    // R5 edge line 200 (group 6 bit 8), parent 1
    bus_write(CFG, 8'h50, ~32'h100);
    bus_write(CFG, 8'h6C, 32'h100);
    idle(3);
    src[200] = 1'b1; idle(5);
    chk("R5 irq1 edge", {31'd0, irq1_o}, 1);
    chk("R10 irq0 idle", {31'd0, irq0_o}, 0);
    bus_read(STS, 8'h34, 32'h100, "R5 view1 w6");
    bus_read(STS, 8'h50, 32'h0, "R8 view0 w6");
    bus_read(STS, 8'h7C, 32'h40, "R9 summary out1 group6");
    src[200] = 1'b0; idle(5);
    bus_read(STS, 8'h34, 32'h100, "R5 sticky after release");

    // R6 write-one clear
    bus_write(STS, 8'h18, ~32'h100); idle(2);
    bus_read(STS, 8'h34, 32'h100, "R6 zero write ignored");
    bus_write(STS, 8'h18, 32'h100); idle(3);
    bus_read(STS, 8'h34, 32'h0, "R6 cleared");
    chk("R10 irq1 after clear", {31'd0, irq1_o}, 0);

    // R8 enable hides and reveals retained edge
    src[200] = 1'b1; idle(5); src[200] = 1'b0;
    bus_write(CFG, 8'h6C, 32'h0); idle(3);
    chk("R8 irq1 disabled", {31'd0, irq1_o}, 0);
    bus_read(STS, 8'h34, 32'h0, "R8 disabled view");
    bus_write(CFG, 8'h6C, 32'h100); idle(3);
    chk("R8 irq1 re-enabled", {31'd0, irq1_o}, 1);
    bus_read(STS, 8'h34, 32'h100, "R8 re-enabled view");
    bus_write(STS, 8'h18, 32'h100); idle(3);

    // R5 falling-edge sense
    bus_write(CFG, 8'h34, 32'h100); idle(5);
    bus_read(STS, 8'h34, 32'h0, "R5 sense change no edge");
    src[200] = 1'b1; idle(5);
    bus_read(STS, 8'h34, 32'h0, "R5 rising ignored when falling");
    src[200] = 1'b0; idle(5);
    bus_read(STS, 8'h34, 32'h100, "R5 falling edge latched");
    bus_write(STS, 8'h18, 32'h100);
    bus_write(CFG, 8'h34, 32'h0); idle(3);
    bus_read(STS, 8'h34, 32'h0, "R6 cleared after falling");

    // R7 edge and clear in the same cycle
    @(negedge clk) src[200] = 1'b1;
    @(posedge clk); @(posedge clk);
    bus_write(STS, 8'h18, 32'h100);
    idle(2);
    bus_read(STS, 8'h34, 32'h100, "R7 edge wins over clear");

    // R9/R10 both parents at once
    bus_write(CFG, 8'h58, 32'h100);
    src[40] = 1'b1; idle(5);
    bus_read(STS, 8'h7C, 32'h240, "R9 summary both halves");
    chk("R10 irq0 both", {31'd0, irq0_o}, 1);
    chk("R10 irq1 both", {31'd0, irq1_o}, 1);

    idle(4);
    chk("R2 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule